// File: doc/BRIEF.md
# Register Block with Configurable Access-Error Response

This block is a small memory-mapped register file behind a single-outstanding CPU port. Each request is a one-cycle strobe carrying a byte address, a write flag, 32-bit write data and byte strobes. Each request completes with exactly one acknowledge pulse. The pulse carries read data and an error bit. Locally held registers answer at a fixed latency. The block holds a read/write storage word, a read-only constant, a write-only storage word whose value is exported to hardware, and one shared address that reads a constant but writes a separate exported word.

Four address windows are not decoded locally. Requests that fall in them are forwarded to external storage through a request/acknowledge handshake.
- The window at 0x20 allows read and write.
- The window at 0x28 is read-only.
- The window at 0x30 is write-only.
- The window at 0x40 is a four-word register file.

The handshake presents a one-hot request, a direction flag, a word index, write data and a 32-bit bit-enable mask. It waits for a read or write acknowledge from the selected window.

Two elaboration parameters choose which accesses report an error:
- accesses to unmapped offsets;
- accesses in a direction that the target does not allow.

Top module: `regblk_errrsp`

## Requirements
- R1: Offset 0x00 is a read/write word that resets to 40. A write updates only the bytes whose strobe bit is set (strobe bit k covers data bits 8k+7..8k), and a later read returns the merged value with error 0.
- R2: Offset 0x04 reads the constant 80 with error 0. A write to it changes nothing and responds with error equal to ERR_ON_WRONG_DIR.
- R3: Offset 0x08 is a write-only word that resets to 100 and is driven on `wonly_value`. A write updates it with error 0. A read returns 0 with error equal to ERR_ON_WRONG_DIR and leaves `wonly_value` unchanged.
- R4: Any offset outside the decoded ones (for example 0x18) returns read data 0 and changes no register or external storage. It responds with error equal to ERR_ON_UNMAPPED, for reads and writes alike.
- R5: Offset 0x1C reads the constant 200. A write there goes to a separate word driven on `combo_wo_value`, which resets to 0. Neither direction reports an error.
- R6: An allowed access in a window is forwarded. `ext_req` is one-hot: bit 0 for 0x20–0x27, bit 1 for 0x28–0x2F, bit 2 for 0x30–0x37, bit 3 for 0x40–0x4F. The remaining outputs are set as follows, and all of them, with `ext_req`, stay stable until the selected acknowledge:
  - `ext_req_is_wr` is the write flag;
  - `ext_addr` is the word index within the window, (address − base) / 4;
  - `ext_wr_data` is the write data;
  - `ext_wr_biten` is the byte strobes expanded to bit enables.
- R7: A write to the 0x28 window or a read from the 0x30 window is not forwarded (`ext_req` stays 0). It returns data 0 with error equal to ERR_ON_WRONG_DIR, and external storage is untouched.
- R8: A locally answered access acknowledges in the cycle after the request. A forwarded access acknowledges in the cycle after the external acknowledge is sampled.
- R9: A forwarded read returns the window's `ext_rd_data` slice, bits 32w+31..32w for window w. Every write response returns data 0.
- R10: While `rst` is high, all storage words return to their reset values, any pending external request is dropped, and no acknowledge is produced for the abandoned access.
- R11: The 0x40 window spans four words. Offset 0x4C is forwarded with word index 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Byte address (low two bits ignored) |
| cpu_wdata | input | 32 | Write data |
| cpu_strb | input | 4 | Byte write strobes |
| cpu_ack | output | 1 | Response pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_ack |
| cpu_err | output | 1 | Error flag, valid with cpu_ack |
| wonly_value | output | 32 | Value of the write-only word at 0x08 |
| combo_wo_value | output | 32 | Value of the write side of 0x1C |
| ext_req | output | 4 | One-hot forwarded request per window |
| ext_req_is_wr | output | 1 | Direction of the forwarded request |
| ext_addr | output | 2 | Word index inside the window |
| ext_wr_data | output | 32 | Forwarded write data |
| ext_wr_biten | output | 32 | Forwarded bit enables |
| ext_rd_ack | input | 4 | Read acknowledge per window |
| ext_wr_ack | input | 4 | Write acknowledge per window |
| ext_rd_data | input | 128 | Read data per window, 32 bits each |

## Verification
The assertions assume that the CPU side issues no new request while a forwarded access is pending. They also assume that external windows acknowledge only the window currently requested, and only in the requested direction. The bench drives one access at a time and waits for its acknowledge before the next strobe. Its external storage models raise a single acknowledge of the matching kind one cycle after they see a request. Two instances run the same stimulus side by side, one with both error options enabled and one with both disabled, so each option value is checked.

// File: rtl/regblk_pkg.sv
package regblk_pkg;

    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int STRB_W     = DATA_W / 8;
    localparam int NUM_WIN    = 4;
    localparam int WIN_IDX_W  = 2;
    localparam int WORD_SHIFT = $clog2(STRB_W);

    localparam logic [ADDR_W-1:0] OFS_STORE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CONST = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_WONLY = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_COMBO = 8'h1C;

    typedef enum logic [2:0] {
        TGT_STORE,
        TGT_CONST,
        TGT_WONLY,
        TGT_COMBO,
        TGT_EXT,
        TGT_NONE
    } tgt_e;

    typedef struct packed {
        tgt_e                 tgt;
        logic [WIN_IDX_W-1:0] win;
        logic [WIN_IDX_W-1:0] idx;
        logic                 dir_bad;
    } dec_t;

    function automatic logic [ADDR_W-1:0] win_base(input int w);
        case (w)
            0:       return 8'h20;
            1:       return 8'h28;
            2:       return 8'h30;
            default: return 8'h40;
        endcase
    endfunction

    function automatic int win_words(input int w);
        return (w == 3) ? 4 : 2;
    endfunction

    function automatic logic win_rd_ok(input int w);
        return w != 2;
    endfunction

    function automatic logic win_wr_ok(input int w);
        return w != 1;
    endfunction

    function automatic logic [DATA_W-1:0] byte_mask(input logic [STRB_W-1:0] s);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < STRB_W; b++) m[b*8 +: 8] = {8{s[b]}};
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] merge_bytes(input logic [DATA_W-1:0] old_v,
                                                      input logic [DATA_W-1:0] new_v,
                                                      input logic [STRB_W-1:0] s);
        logic [DATA_W-1:0] m;
        m = byte_mask(s);
        return (old_v & ~m) | (new_v & m);
    endfunction

endpackage

// File: rtl/regblk_decode.sv
module regblk_decode
    import regblk_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_wr,
    output dec_t              dec
);

    logic [ADDR_W-1:0] aw;
    assign aw = {addr[ADDR_W-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};

    always_comb begin
        dec         = '0;
        dec.tgt     = TGT_NONE;
        dec.dir_bad = 1'b0;
        if (aw == OFS_STORE) begin
            dec.tgt = TGT_STORE;
        end else if (aw == OFS_CONST) begin
            dec.tgt     = TGT_CONST;
            dec.dir_bad = is_wr;
        end else if (aw == OFS_WONLY) begin
            dec.tgt     = TGT_WONLY;
            dec.dir_bad = !is_wr;
        end else if (aw == OFS_COMBO) begin
            dec.tgt = TGT_COMBO;
        end else begin
            for (int w = 0; w < NUM_WIN; w++) begin
                if ({1'b0, aw} >= {1'b0, win_base(w)} &&
                    {1'b0, aw} <  {1'b0, win_base(w)} + 9'(win_words(w) * STRB_W)) begin
                    dec.tgt     = TGT_EXT;
                    dec.win     = WIN_IDX_W'(w);
                    dec.idx     = WIN_IDX_W'((aw - win_base(w)) >> WORD_SHIFT);
                    dec.dir_bad = is_wr ? !win_wr_ok(w) : !win_rd_ok(w);
                end
            end
        end
    end

endmodule

// File: rtl/regblk_reg.sv
module regblk_reg
    import regblk_pkg::*;
#(
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] strb,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= RST_VAL;
        else if (we) q <= merge_bytes(q, wdata, strb);
    end

endmodule

// File: rtl/regblk_extfwd.sv
module regblk_extfwd
    import regblk_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [WIN_IDX_W-1:0]      start_win,
    input  logic                      start_wr,
    input  logic [WIN_IDX_W-1:0]      start_idx,
    input  logic [DATA_W-1:0]         start_wdata,
    input  logic [STRB_W-1:0]         start_strb,
    output logic [NUM_WIN-1:0]        ext_req,
    output logic                      ext_req_is_wr,
    output logic [WIN_IDX_W-1:0]      ext_addr,
    output logic [DATA_W-1:0]         ext_wr_data,
    output logic [DATA_W-1:0]         ext_wr_biten,
    input  logic [NUM_WIN-1:0]        ext_rd_ack,
    input  logic [NUM_WIN-1:0]        ext_wr_ack,
    input  logic [NUM_WIN*DATA_W-1:0] ext_rd_data,
    output logic                      busy,
    output logic                      done,
    output logic [DATA_W-1:0]         done_data
);

    logic [WIN_IDX_W-1:0] win_q;
    logic                 wr_q;
    logic [WIN_IDX_W-1:0] idx_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [STRB_W-1:0]    strb_q;
    logic                 ack_sel;

    assign ack_sel = wr_q ? ext_wr_ack[win_q] : ext_rd_ack[win_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            done_data <= '0;
            win_q     <= '0;
            wr_q      <= 1'b0;
            idx_q     <= '0;
            wdata_q   <= '0;
            strb_q    <= '0;
        end else begin
            done <= 1'b0;
            if (busy && ack_sel) begin
                busy      <= 1'b0;
                done      <= 1'b1;
                done_data <= wr_q ? '0 : ext_rd_data[win_q*DATA_W +: DATA_W];
            end else if (start) begin
                busy    <= 1'b1;
                win_q   <= start_win;
                wr_q    <= start_wr;
                idx_q   <= start_idx;
                wdata_q <= start_wdata;
                strb_q  <= start_strb;
            end
        end
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_req
        assign ext_req[w] = busy && (win_q == WIN_IDX_W'(w));
    end

    assign ext_req_is_wr = wr_q;
    assign ext_addr      = idx_q;
    assign ext_wr_data   = wdata_q;
    assign ext_wr_biten  = byte_mask(strb_q);

    a_r6_req_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ext_req));

    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack_sel) |=> (busy && $stable(ext_req) && $stable(ext_addr)
                                && $stable(ext_req_is_wr) && $stable(ext_wr_data)));

    a_r8_done_after_ack: assert property (@(posedge clk) disable iff (rst)
        (busy && ack_sel) |=> (done && ext_req == '0));

    a_r10_reset_drops: assert property (@(posedge clk)
        rst |=> (!busy && !done));

endmodule

// File: rtl/regblk_errrsp.sv
module regblk_errrsp
    import regblk_pkg::*;
#(
    parameter bit                ERR_ON_UNMAPPED  = 1'b1,
    parameter bit                ERR_ON_WRONG_DIR = 1'b1,
    parameter logic [DATA_W-1:0] STORE_RST        = 32'd40,
    parameter logic [DATA_W-1:0] WONLY_RST        = 32'd100,
    parameter logic [DATA_W-1:0] COMBO_WO_RST     = 32'd0,
    parameter logic [DATA_W-1:0] CONST_VAL        = 32'd80,
    parameter logic [DATA_W-1:0] COMBO_RO_VAL     = 32'd200
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cpu_req,
    input  logic                      cpu_wr,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic [STRB_W-1:0]         cpu_strb,
    output logic                      cpu_ack,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic                      cpu_err,
    output logic [DATA_W-1:0]         wonly_value,
    output logic [DATA_W-1:0]         combo_wo_value,
    output logic [NUM_WIN-1:0]        ext_req,
    output logic                      ext_req_is_wr,
    output logic [WIN_IDX_W-1:0]      ext_addr,
    output logic [DATA_W-1:0]         ext_wr_data,
    output logic [DATA_W-1:0]         ext_wr_biten,
    input  logic [NUM_WIN-1:0]        ext_rd_ack,
    input  logic [NUM_WIN-1:0]        ext_wr_ack,
    input  logic [NUM_WIN*DATA_W-1:0] ext_rd_data
);

    localparam int NUM_REG = 3;
    localparam logic [DATA_W-1:0] REG_RST [NUM_REG] = '{STORE_RST, WONLY_RST, COMBO_WO_RST};

    dec_t              dec;
    logic              busy;
    logic              accept;
    logic              fwd_go;
    logic              local_go;
    logic              fwd_done;
    logic [DATA_W-1:0] fwd_data;
    logic [NUM_REG-1:0] reg_we;
    logic [DATA_W-1:0] reg_q [NUM_REG];
    logic [DATA_W-1:0] rd_val;
    logic              err_val;
    logic              ack_q;
    logic              err_q;
    logic [DATA_W-1:0] rdata_q;

    regblk_decode u_dec (
        .addr  (cpu_addr),
        .is_wr (cpu_wr),
        .dec   (dec)
    );

    assign accept   = cpu_req && !busy;
    assign fwd_go   = accept && dec.tgt == TGT_EXT && !dec.dir_bad;
    assign local_go = accept && !fwd_go;

    assign reg_we[0] = accept && cpu_wr && dec.tgt == TGT_STORE;
    assign reg_we[1] = accept && cpu_wr && dec.tgt == TGT_WONLY;
    assign reg_we[2] = accept && cpu_wr && dec.tgt == TGT_COMBO;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        regblk_reg #(.RST_VAL(REG_RST[g])) u_reg (
            .clk   (clk),
            .rst   (rst),
            .we    (reg_we[g]),
            .wdata (cpu_wdata),
            .strb  (cpu_strb),
            .q     (reg_q[g])
        );
    end

    assign wonly_value    = reg_q[1];
    assign combo_wo_value = reg_q[2];

    always_comb begin
        rd_val  = '0;
        err_val = 1'b0;
        case (dec.tgt)
            TGT_STORE: rd_val = reg_q[0];
            TGT_CONST: rd_val = CONST_VAL;
            TGT_COMBO: rd_val = COMBO_RO_VAL;
            TGT_NONE:  err_val = ERR_ON_UNMAPPED;
            default:   rd_val = '0;
        endcase
        if (dec.dir_bad) begin
            rd_val  = '0;
            err_val = ERR_ON_WRONG_DIR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= local_go;
            err_q   <= local_go && err_val;
            rdata_q <= (local_go && !cpu_wr) ? rd_val : '0;
        end
    end

    regblk_extfwd u_fwd (
        .clk           (clk),
        .rst           (rst),
        .start         (fwd_go),
        .start_win     (dec.win),
        .start_wr      (cpu_wr),
        .start_idx     (dec.idx),
        .start_wdata   (cpu_wdata),
        .start_strb    (cpu_strb),
        .ext_req       (ext_req),
        .ext_req_is_wr (ext_req_is_wr),
        .ext_addr      (ext_addr),
        .ext_wr_data   (ext_wr_data),
        .ext_wr_biten  (ext_wr_biten),
        .ext_rd_ack    (ext_rd_ack),
        .ext_wr_ack    (ext_wr_ack),
        .ext_rd_data   (ext_rd_data),
        .busy          (busy),
        .done          (fwd_done),
        .done_data     (fwd_data)
    );

    assign cpu_ack   = ack_q || fwd_done;
    assign cpu_rdata = ack_q ? rdata_q : fwd_data;
    assign cpu_err   = err_q;

    a_r8_local_latency: assert property (@(posedge clk) disable iff (rst)
        local_go |=> (cpu_ack && ext_req == '0));

    a_r4_unmapped_rsp: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.tgt == TGT_NONE) |=> (cpu_ack && cpu_rdata == '0
                                             && cpu_err == ERR_ON_UNMAPPED));

    a_r7_no_forward: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.dir_bad) |=> (ext_req == '0 && cpu_err == ERR_ON_WRONG_DIR));

    a_r3_wonly_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_we[1] |=> $stable(wonly_value));

    a_r9_err_with_ack: assert property (@(posedge clk) disable iff (rst)
        cpu_err |-> cpu_ack);

endmodule

// File: tb/regblk_errrsp_tb.sv
`timescale 1ns/1ps

module regblk_ext_model (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   req,
    input  logic         is_wr,
    input  logic [1:0]   addr,
    input  logic [31:0]  wdata,
    input  logic [31:0]  biten,
    output logic [3:0]   rd_ack,
    output logic [3:0]   wr_ack,
    output logic [127:0] rdata
);
    logic [31:0] mem [4][4];

    always @(posedge clk) begin
        if (rst) begin
            rd_ack <= '0;
            wr_ack <= '0;
            rdata  <= '0;
        end else begin
            for (int w = 0; w < 4; w++) begin
                rd_ack[w] <= req[w] && !is_wr && !(rd_ack[w] || wr_ack[w]);
                wr_ack[w] <= req[w] &&  is_wr && !(rd_ack[w] || wr_ack[w]);
                if (req[w] && !(rd_ack[w] || wr_ack[w])) begin
                    if (is_wr) mem[w][addr] <= (mem[w][addr] & ~biten) | (wdata & biten);
                    else       rdata[w*32 +: 32] <= mem[w][addr];
                end
            end
        end
    end
endmodule

module regblk_errrsp_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req = 1'b0;
    logic         cpu_wr = 1'b0;
    logic [7:0]   cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [3:0]   cpu_strb = '0;

    logic         ack_s, err_s, ack_l, err_l;
    logic [31:0]  rdata_s, rdata_l, wov_s, wov_l, cwo_s, cwo_l;
    logic [3:0]   req_s, req_l, rack_s, rack_l, wack_s, wack_l;
    logic         isw_s, isw_l;
    logic [1:0]   ea_s, ea_l;
    logic [31:0]  ewd_s, ewd_l, ebe_s, ebe_l;
    logic [127:0] erd_s, erd_l;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    typedef struct packed {
        logic [31:0] d;
        logic        e;
        logic [7:0]  rq;
    } exp_t;

    exp_t q_s[$];
    exp_t q_l[$];
    exp_t ex_s, ex_l;

    always #10 clk = ~clk;

    regblk_errrsp #(.ERR_ON_UNMAPPED(1'b1), .ERR_ON_WRONG_DIR(1'b1)) u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_strb(cpu_strb), .cpu_ack(ack_s), .cpu_rdata(rdata_s),
        .cpu_err(err_s), .wonly_value(wov_s), .combo_wo_value(cwo_s), .ext_req(req_s),
        .ext_req_is_wr(isw_s), .ext_addr(ea_s), .ext_wr_data(ewd_s), .ext_wr_biten(ebe_s),
        .ext_rd_ack(rack_s), .ext_wr_ack(wack_s), .ext_rd_data(erd_s));

    regblk_errrsp #(.ERR_ON_UNMAPPED(1'b0), .ERR_ON_WRONG_DIR(1'b0)) u_dut_lax (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_strb(cpu_strb), .cpu_ack(ack_l), .cpu_rdata(rdata_l),
        .cpu_err(err_l), .wonly_value(wov_l), .combo_wo_value(cwo_l), .ext_req(req_l),
        .ext_req_is_wr(isw_l), .ext_addr(ea_l), .ext_wr_data(ewd_l), .ext_wr_biten(ebe_l),
        .ext_rd_ack(rack_l), .ext_wr_ack(wack_l), .ext_rd_data(erd_l));

    regblk_ext_model u_mod (
        .clk(clk), .rst(rst), .req(req_s), .is_wr(isw_s), .addr(ea_s), .wdata(ewd_s),
        .biten(ebe_s), .rd_ack(rack_s), .wr_ack(wack_s), .rdata(erd_s));

    regblk_ext_model u_mod_lax (
        .clk(clk), .rst(rst), .req(req_l), .is_wr(isw_l), .addr(ea_l), .wdata(ewd_l),
        .biten(ebe_l), .rd_ack(rack_l), .wr_ack(wack_l), .rdata(erd_l));

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // Monitor: pops the scoreboard whenever a response appears.
    always @(negedge clk) begin
        if (!rst && ack_s) begin
            if (q_s.size() == 0) chk(1'b0, "R10", {31'b0, ack_s}, 64'd0);
            else begin
                ex_s = q_s.pop_front();
                chk(rdata_s == ex_s.d && err_s == ex_s.e, $sformatf("R%0d strict", ex_s.rq),
                    {err_s, rdata_s}, {ex_s.e, ex_s.d});
            end
        end
        if (!rst && ack_l) begin
            if (q_l.size() == 0) chk(1'b0, "R10", {31'b0, ack_l}, 64'd0);
            else begin
                ex_l = q_l.pop_front();
                chk(rdata_l == ex_l.d && err_l == ex_l.e, $sformatf("R%0d lax", ex_l.rq),
                    {err_l, rdata_l}, {ex_l.e, ex_l.d});
            end
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(1'b0, "watchdog", 64'(cyc), 64'd20000);
            finish_run();
        end
    end

    // Driver: one access, pushes the expected response, checks latency
    // and, for forwarded accesses, the request presented to the window.
    task automatic access(input bit wr, input logic [7:0] a, input logic [31:0] d,
                          input logic [3:0] s, input logic [31:0] exp_d, input bit exp_es,
                          input bit exp_el, input int exp_lat, input int win,
                          input logic [1:0] idx, input logic [7:0] rq);
        int lat;
        q_s.push_back('{d: exp_d, e: exp_es, rq: rq});
        q_l.push_back('{d: exp_d, e: exp_el, rq: rq});
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d; cpu_strb = s;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                cpu_req = 1'b0;
                if (exp_lat == 3) begin
                    chk(req_s == 4'(1 << win) && isw_s == wr && ea_s == idx &&
                        ebe_s == {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}} && ewd_s == d,
                        "R6 forwarded request", {req_s, isw_s, ea_s, ebe_s},
                        {4'(1 << win), wr, idx, {8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}});
                end else begin
                    chk(req_s == 4'b0, "R7 not forwarded", 64'(req_s), 64'd0);
                end
            end
        end while (!ack_s && lat < 12);
        chk(lat == exp_lat && ack_l, "R8 latency", 64'(lat), 64'(exp_lat));
        @(negedge clk);
    endtask

    initial begin
        for (int w = 0; w < 4; w++)
            for (int i = 0; i < 4; i++) begin
                u_mod.mem[w][i] = '0;
                u_mod_lax.mem[w][i] = '0;
            end
        u_mod.mem[0][0] = 32'h8C;        u_mod_lax.mem[0][0] = 32'h8C;
        u_mod.mem[0][1] = 32'hFFFFFFFF;  u_mod_lax.mem[0][1] = 32'hFFFFFFFF;
        u_mod.mem[1][0] = 32'hB4;        u_mod_lax.mem[1][0] = 32'hB4;
        u_mod.mem[2][0] = 32'hC8;        u_mod_lax.mem[2][0] = 32'hC8;

        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!ack_s && req_s == 0 && wov_s == 32'd100 && cwo_s == 0, "R10 reset state",
            {ack_s, req_s, wov_s}, {1'b0, 4'd0, 32'd100});
        rst = 1'b0;
        @(negedge clk);

        // R1 storage word with byte strobes
        access(0, 8'h00, 0, 4'hF, 32'd40, 0, 0, 1, 0, 0, 8'd1);
        access(1, 8'h00, 32'd61, 4'hF, 0, 0, 0, 1, 0, 0, 8'd1);
        access(0, 8'h00, 0, 4'hF, 32'd61, 0, 0, 1, 0, 0, 8'd1);
        access(1, 8'h00, 32'hFFFFAB00, 4'b0010, 0, 0, 0, 1, 0, 0, 8'd1);
        access(0, 8'h00, 0, 4'hF, 32'h0000AB3D, 0, 0, 1, 0, 0, 8'd1);

        // R2 constant
        access(0, 8'h04, 0, 4'hF, 32'd80, 0, 0, 1, 0, 0, 8'd2);
        access(1, 8'h04, 32'd81, 4'hF, 0, 1, 0, 1, 0, 0, 8'd2);
        access(0, 8'h04, 0, 4'hF, 32'd80, 0, 0, 1, 0, 0, 8'd2);

        // R3 write-only word
        access(0, 8'h08, 0, 4'hF, 0, 1, 0, 1, 0, 0, 8'd3);
        chk(wov_s == 32'd100 && wov_l == 32'd100, "R3 unchanged by read", 64'(wov_s), 64'd100);
        access(1, 8'h08, 32'd101, 4'hF, 0, 0, 0, 1, 0, 0, 8'd3);
        chk(wov_s == 32'd101, "R3 written value", 64'(wov_s), 64'd101);

        // R4 unmapped offset
        access(0, 8'h18, 0, 4'hF, 0, 1, 0, 1, 0, 0, 8'd4);
        access(1, 8'h18, 32'h8C, 4'hF, 0, 1, 0, 1, 0, 0, 8'd4);
        chk(wov_s == 32'd101 && cwo_s == 0, "R4 no state change", {wov_s, cwo_s}, {32'd101, 32'd0});
        access(0, 8'h00, 0, 4'hF, 32'h0000AB3D, 0, 0, 1, 0, 0, 8'd4);

        // R5 shared address
        access(0, 8'h1C, 0, 4'hF, 32'd200, 0, 0, 1, 0, 0, 8'd5);
        access(1, 8'h1C, 32'h8C, 4'hF, 0, 0, 0, 1, 0, 0, 8'd5);
        chk(cwo_s == 32'h8C && cwo_l == 32'h8C, "R5 write side", 64'(cwo_s), 64'h8C);
        access(0, 8'h1C, 0, 4'hF, 32'd200, 0, 0, 1, 0, 0, 8'd5);

        // R6/R9 read/write window
        access(0, 8'h20, 0, 4'hF, 32'h8C, 0, 0, 3, 0, 2'd0, 8'd9);
        access(1, 8'h20, 32'h8D, 4'hF, 0, 0, 0, 3, 0, 2'd0, 8'd9);
        access(0, 8'h20, 0, 4'hF, 32'h8D, 0, 0, 3, 0, 2'd0, 8'd9);
        access(1, 8'h24, 32'h11223344, 4'b0001, 0, 0, 0, 3, 0, 2'd1, 8'd6);
        access(0, 8'h24, 0, 4'hF, 32'hFFFFFF44, 0, 0, 3, 0, 2'd1, 8'd6);

        // R7 read-only and write-only windows
        access(0, 8'h28, 0, 4'hF, 32'hB4, 0, 0, 3, 1, 2'd0, 8'd9);
        access(1, 8'h28, 32'hB5, 4'hF, 0, 1, 0, 1, 0, 0, 8'd7);
        access(0, 8'h28, 0, 4'hF, 32'hB4, 0, 0, 3, 1, 2'd0, 8'd7);
        access(0, 8'h30, 0, 4'hF, 0, 1, 0, 1, 0, 0, 8'd7);
        chk(u_mod.mem[2][0] == 32'hC8, "R7 memory untouched", 64'(u_mod.mem[2][0]), 64'hC8);
        access(1, 8'h30, 32'hC9, 4'hF, 0, 0, 0, 3, 2, 2'd0, 8'd6);
        chk(u_mod.mem[2][0] == 32'hC9 && u_mod_lax.mem[2][0] == 32'hC9, "R6 window write",
            64'(u_mod.mem[2][0]), 64'hC9);

        // R11 register-file window
        access(0, 8'h40, 0, 4'hF, 0, 0, 0, 3, 3, 2'd0, 8'd11);
        access(1, 8'h4C, 32'hD0, 4'hF, 0, 0, 0, 3, 3, 2'd3, 8'd11);
        access(0, 8'h4C, 0, 4'hF, 32'hD0, 0, 0, 3, 3, 2'd3, 8'd11);

        // R10 reset while a forwarded access is pending
        cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 8'h20; cpu_strb = 4'hF;
        @(negedge clk);
        cpu_req = 1'b0;
        chk(req_s == 4'b0001, "R10 pending before reset", 64'(req_s), 64'd1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_s == 0 && !ack_s && wov_s == 32'd100 && cwo_s == 0, "R10 reset mid-access",
            {req_s, ack_s, wov_s}, {4'd0, 1'b0, 32'd100});
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!ack_s && req_s == 0, "R10 no late response", {ack_s, req_s}, 64'd0);
        access(0, 8'h00, 0, 4'hF, 32'd40, 0, 0, 1, 0, 0, 8'd10);

        repeat (2) @(negedge clk);
        chk(q_s.size() == 0 && q_l.size() == 0, "R8 all responses seen", 64'(q_s.size()), 64'd0);
        finish_run();
    end

endmodule